// File: doc/BRIEF.md
# Two-Way Set-Associative Data Cache

This block is a small one-word-per-line data cache placed between a processor's load/store port and its data memory. A 32-bit byte address is split into a 27-bit tag (bits [31:5]), a 3-bit set index (bits [4:2]) and a 2-bit byte offset (bits [1:0]). This gives eight sets with two ways each. Every way holds a valid bit, a 2-bit recency value, a tag and one 32-bit word.

A read is looked up in the same cycle it is presented, and the result is registered. The output word comes from the matching way on a hit, or from the memory read data on a miss. A miss also installs the memory word in a way picked by the replacement logic. Stores write either a single byte lane or the whole word, depending on a mode input. A store updates a matching way in place, or allocates a victim way when no way matches.

Top module: `dcache2w`

## Requirements
- R1: The set index is address bits [4:2] and the tag is bits [31:5]. Reads ignore bits [1:0], and equal tags in different sets are independent entries.
- R2: A read whose set holds a valid way with an equal tag raises `hit` and returns that way's word on `rd_data` after the next rising clock edge.
- R3: A read with no matching valid way drives `hit` low and returns `mem_rdata`, sampled at the request edge, on `rd_data` after that edge.
- R4: A read miss writes the memory word, the tag and valid=1 into the victim way, so that an immediate re-read of the same word hits.
- R5: The victim is an invalid way if one exists (way 0 before way 1). Otherwise it is the way with the smaller recency value.
- R6: Every read or store sets the accessed way's recency to 3 and decrements the other way's recency, saturating at 0. The least recently used of two ways is therefore evicted.
- R7: A store with `byte_mode`=0 writes all four lanes: `wr_data[7:0]` goes to byte 0 (bits 7:0 of the word) and `wr_data[31:24]` goes to byte 3.
- R8: A store with `byte_mode`=1 writes only `wr_data[7:0]`, into the lane chosen by the offset (00 selects bits 7:0, 11 selects bits 31:24). The other lanes keep their contents.
- R9: A store whose tag matches a valid way updates that way in place and never allocates the second way, so a tag is present at most once in a set.
- R10: A store miss allocates the victim way with the new tag and valid=1. Lanes that the store does not write take the matching bytes of `mem_rdata`.
- R11: Synchronous active-high `rst` clears all valid bits and recency values and sets `rd_data` and `hit` to 0. The next read of any address misses.
- R12: `rd_data` and `hit` change only on a read. When `rd_en` and `wr_en` are both high, the store is performed and the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Store request (takes priority over rd_en) |
| byte_mode | input | 1 | Store width: 0 = word, 1 = single byte |
| addr | input | 32 | Byte address of the access |
| wr_data | input | 32 | Store data |
| mem_rdata | input | 32 | Word that main memory returns for `addr` |
| rd_data | output | 32 | Registered read result |
| hit | output | 1 | Registered hit flag of the last read |

## Verification
The hardest state to reach from the ports is an eviction decided by recency rather than by validity. This needs a set where both ways are valid and their recency values have been steered by a known access order. The bench fills one set with two tags and re-touches one of them, then brings in a third tag. It then checks that the untouched tag misses and the touched tag still hits. A second difficult case is a store hit in a set whose other way is the older one. If the design wrongly allocates, that way is evicted, and a read of it shows the fault.

// File: rtl/dc_pkg.sv
package dc_pkg;
  localparam int LANE_W  = 8;
  localparam int REC_W   = 2;
  localparam logic [REC_W-1:0] REC_NEWEST = '1;
endpackage

// File: rtl/dc_way.sv
module dc_way #(
  parameter int SET_W  = 3,
  parameter int TAG_W  = 27,
  parameter int LANES  = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [SET_W-1:0]                  idx,
  input  logic                              touch,
  input  logic                              chosen,
  input  logic                              wr_en,
  input  logic [LANES-1:0]                  lane_we,
  input  logic [TAG_W-1:0]                  wr_tag,
  input  logic [LANES*dc_pkg::LANE_W-1:0]   wr_word,
  output logic                              valid,
  output logic [dc_pkg::REC_W-1:0]          rec,
  output logic [TAG_W-1:0]                  tag,
  output logic [LANES*dc_pkg::LANE_W-1:0]   word
);
  localparam int SETS = 1 << SET_W;
  localparam int LW   = dc_pkg::LANE_W;

  logic [SETS-1:0]          valid_r;
  logic [dc_pkg::REC_W-1:0] rec_r [SETS];
  logic [TAG_W-1:0]         tag_mem [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_r <= '0;
      for (int s = 0; s < SETS; s++) rec_r[s] <= '0;
    end else begin
      if (touch) begin
        if (chosen)
          rec_r[idx] <= dc_pkg::REC_NEWEST;
        else if (rec_r[idx] != '0)
          rec_r[idx] <= rec_r[idx] - 1'b1;
      end
      if (wr_en) valid_r[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[idx] <= wr_tag;
  end

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LW-1:0] lane_mem [SETS];
      always_ff @(posedge clk) begin
        if (wr_en && lane_we[l]) lane_mem[idx] <= wr_word[l*LW +: LW];
      end
      assign word[l*LW +: LW] = lane_mem[idx];
    end
  endgenerate

  assign valid = valid_r[idx];
  assign rec   = rec_r[idx];
  assign tag   = tag_mem[idx];
endmodule

// File: rtl/dc_victim.sv
module dc_victim (
  input  logic [1:0]               valid,
  input  logic [dc_pkg::REC_W-1:0] rec0,
  input  logic [dc_pkg::REC_W-1:0] rec1,
  output logic                     victim
);
  always_comb begin
    if (!valid[0])      victim = 1'b0;
    else if (!valid[1]) victim = 1'b1;
    else                victim = (rec1 < rec0);
  end
endmodule

// File: rtl/dcache2w.sv
module dcache2w #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SET_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              byte_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              hit
);
  localparam int LW    = dc_pkg::LANE_W;
  localparam int LANES = DATA_W / LW;
  localparam int OFF_W = $clog2(LANES);
  localparam int TAG_W = ADDR_W - SET_W - OFF_W;
  localparam int WAYS  = 2;

  logic [TAG_W-1:0] a_tag;
  logic [SET_W-1:0] a_idx;
  logic [OFF_W-1:0] a_off;
  assign a_tag = addr[ADDR_W-1 -: TAG_W];
  assign a_idx = addr[OFF_W +: SET_W];
  assign a_off = addr[OFF_W-1:0];

  logic                     v_q   [WAYS];
  logic [dc_pkg::REC_W-1:0] rec_q [WAYS];
  logic [TAG_W-1:0]         tag_q [WAYS];
  logic [DATA_W-1:0]        word_q[WAYS];
  logic [WAYS-1:0]          way_hit;
  logic [WAYS-1:0]          way_we;
  logic                     any_hit, hit_way, victim, sel_way, access;
  logic [LANES-1:0]         byte_mask, lane_we;
  logic [DATA_W-1:0]        fill_word;

  assign access  = rd_en | wr_en;
  assign any_hit = |way_hit;
  assign hit_way = way_hit[1];
  assign sel_way = any_hit ? hit_way : victim;

  dc_victim u_victim (
    .valid  ({v_q[1], v_q[0]}),
    .rec0   (rec_q[0]),
    .rec1   (rec_q[1]),
    .victim (victim)
  );

  always_comb begin
    byte_mask = '0;
    byte_mask[a_off] = 1'b1;
    if (!access)       lane_we = '0;
    else if (wr_en)    lane_we = any_hit ? (byte_mode ? byte_mask : '1) : '1;
    else               lane_we = any_hit ? '0 : '1;
  end

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_fill
      logic [LW-1:0] st_byte;
      assign st_byte = byte_mode ? wr_data[LW-1:0] : wr_data[l*LW +: LW];
      assign fill_word[l*LW +: LW] =
        (wr_en && (!byte_mode || byte_mask[l])) ? st_byte : mem_rdata[l*LW +: LW];
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign way_hit[w] = v_q[w] && (tag_q[w] == a_tag);
      assign way_we[w]  = access && (sel_way == w[0]) && (|lane_we);
      dc_way #(.SET_W(SET_W), .TAG_W(TAG_W), .LANES(LANES)) u_way (
        .clk     (clk),
        .rst     (rst),
        .idx     (a_idx),
        .touch   (access),
        .chosen  (sel_way == w[0]),
        .wr_en   (way_we[w]),
        .lane_we (lane_we),
        .wr_tag  (a_tag),
        .wr_word (fill_word),
        .valid   (v_q[w]),
        .rec     (rec_q[w]),
        .tag     (tag_q[w]),
        .word    (word_q[w])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      hit     <= 1'b0;
    end else if (rd_en && !wr_en) begin
      rd_data <= any_hit ? word_q[hit_way] : mem_rdata;
      hit     <= any_hit;
    end
  end
endmodule

// File: rtl/dcache2w_chk.sv
module dcache2w_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] mem_rdata,
  input logic [DATA_W-1:0] rd_data,
  input logic              hit,
  input logic [1:0]        way_hit
);
  assert_hit_flag_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && (|way_hit)) |=> hit);

  assert_miss_data_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && !(|way_hit)) |=> (!hit && rd_data == $past(mem_rdata)));

  assert_refill_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && !$past(rst) && $past(rd_en && !wr_en)
     && addr[ADDR_W-1:2] == $past(addr[ADDR_W-1:2])) |=> hit);

  assert_single_copy_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(way_hit));

  assert_cold_miss_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && $past(rst)) |=> !hit);

  assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && !wr_en) |=> ($stable(rd_data) && $stable(hit)));
endmodule

bind dcache2w dcache2w_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_en     (rd_en),
  .wr_en     (wr_en),
  .addr      (addr),
  .mem_rdata (mem_rdata),
  .rd_data   (rd_data),
  .hit       (hit),
  .way_hit   (way_hit)
);

// File: tb/dcache2w_bench.sv
`timescale 1ns/1ps
module dcache2w_bench;
  logic        clk = 1'b0;
  logic        rst, rd_en, wr_en, byte_mode;
  logic [31:0] addr, wr_data, mem_rdata, rd_data;
  logic        hit;
  int          nchk = 0, nfail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] mdat(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] mk(input int t, input int s, input int o);
    return {t[26:0], s[2:0], o[1:0]};
  endfunction

  assign mem_rdata = mdat(addr);

  dcache2w u_dcache2w (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .byte_mode(byte_mode),
    .addr(addr), .wr_data(wr_data), .mem_rdata(mem_rdata),
    .rd_data(rd_data), .hit(hit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_read(input string req, input logic [31:0] a,
                         input logic eh, input logic [31:0] ed);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    chk({req, " hit"}, {31'd0, hit}, {31'd0, eh});
    chk({req, " data"}, rd_data, ed);
  endtask

  task automatic do_store(input string req, input logic [31:0] a, input logic bm,
                          input logic [31:0] d, input logic with_rd);
    logic [31:0] pd;
    logic        ph;
    @(negedge clk);
    pd = rd_data; ph = hit;
    wr_en = 1'b1; rd_en = with_rd; addr = a; byte_mode = bm; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; byte_mode = 1'b0;
    chk({req, " R12 hold data"}, rd_data, pd);
    chk({req, " R12 hold hit"}, {31'd0, hit}, {31'd0, ph});
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    apply_reset();
    chk("R11 reset data", rd_data, 32'd0);
    chk("R11 reset hit", {31'd0, hit}, 32'd0);
  endtask

  task automatic t_miss_fill();
    do_read("R3 first read miss", mk(1,1,0), 1'b0, mdat(mk(1,1,0)));
    do_read("R4 R1 refill hit any offset", mk(1,1,2), 1'b1, mdat(mk(1,1,0)));
    do_read("R1 other set same tag", mk(1,2,0), 1'b0, mdat(mk(1,2,0)));
  endtask

  task automatic t_replace();
    do_read("R5 second tag miss", mk(2,1,0), 1'b0, mdat(mk(2,1,0)));
    do_read("R5 first tag kept", mk(1,1,0), 1'b1, mdat(mk(1,1,0)));
    do_read("R5 second tag kept", mk(2,1,0), 1'b1, mdat(mk(2,1,0)));
    do_read("R6 touch first", mk(1,1,0), 1'b1, mdat(mk(1,1,0)));
    do_read("R6 third tag miss", mk(3,1,0), 1'b0, mdat(mk(3,1,0)));
    do_read("R6 recent kept", mk(1,1,3), 1'b1, mdat(mk(1,1,0)));
    do_read("R6 older evicted", mk(2,1,0), 1'b0, mdat(mk(2,1,0)));
    do_read("R6 third evicted next", mk(3,1,0), 1'b0, mdat(mk(3,1,0)));
  endtask

  task automatic t_stores();
    do_store("R7 word store miss", mk(9,4,0), 1'b0, 32'h1122_3344, 1'b0);
    do_read("R7 R10 word lanes", mk(9,4,0), 1'b1, 32'h1122_3344);
    do_store("R8 byte off2", mk(9,4,2), 1'b1, 32'hFFFF_FFAB, 1'b0);
    do_read("R8 lane2 only", mk(9,4,0), 1'b1, 32'h11AB_3344);
    do_store("R8 byte off3", mk(9,4,3), 1'b1, 32'h0000_00CD, 1'b0);
    do_store("R8 byte off0", mk(9,4,0), 1'b1, 32'h9999_995E, 1'b0);
    do_read("R8 lanes 3 and 0", mk(9,4,1), 1'b1, 32'hCDAB_335E);
    do_store("R10 byte store miss", mk(5,6,1), 1'b1, 32'h1234_5677, 1'b0);
    do_read("R10 merge with memory", mk(5,6,0), 1'b1,
            (mdat(mk(5,6,0)) & 32'hFFFF_00FF) | 32'h0000_7700);
  endtask

  task automatic t_inplace();
    do_read("R9 fill Q", mk(21,7,0), 1'b0, mdat(mk(21,7,0)));
    do_read("R9 fill P", mk(20,7,0), 1'b0, mdat(mk(20,7,0)));
    do_store("R9 store hit P", mk(20,7,0), 1'b0, 32'hDEAD_BEEF, 1'b0);
    do_read("R9 Q not evicted", mk(21,7,0), 1'b1, mdat(mk(21,7,0)));
    do_read("R9 P updated", mk(20,7,0), 1'b1, 32'hDEAD_BEEF);
  endtask

  task automatic t_both();
    do_store("R12 read with store", mk(30,0,0), 1'b0, 32'h0BAD_F00D, 1'b1);
    do_read("R12 store performed", mk(30,0,0), 1'b1, 32'h0BAD_F00D);
  endtask

  task automatic t_reset_again();
    t_reset();
    do_read("R11 miss after reset", mk(1,1,0), 1'b0, mdat(mk(1,1,0)));
  endtask

  initial begin
    rst = 1'b1; rd_en = 1'b0; wr_en = 1'b0; byte_mode = 1'b0;
    addr = '0; wr_data = '0;
    t_reset();
    t_miss_fill();
    t_replace();
    t_stores();
    t_inplace();
    t_both();
    t_reset_again();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule